// File: doc/BRIEF.md
# Sharing-Aware Exclusive Victim Cache

This block is a small set-associative outer cache that sits behind a private inner cache. Lines enter it only when the inner cache evicts them. A line that comes from memory goes straight to the inner cache, and the block only receives a notification of that fill. When an inner miss hits here, the line is handed back on the response channel in the same cycle. If the line is unshared, its copy here is dropped so that the two levels never hold the same line. If the line is marked as shared, or as likely to be shared, the copy stays here as well. A line counts as likely to be shared when it holds instruction code or when its sharing-history bit is set.

A lookup and a victim insert to the same set can be presented in one cycle as a swap. The victim then moves into the way that the hit line frees, and nothing else is evicted. When a set is full, the replacement choice starts from a 3-bit tree pseudo-LRU per set. It steers away from shared ways whenever an unshared way exists. Evicted dirty lines go out on a writeback port, and that port can apply backpressure to victim inserts. The geometry is 16 sets, 4 ways and 64-byte lines, addressed by line address. The set index is line-address bits [3:0] and the tag is the remaining upper bits.

Top module: `victim_store`

## Requirements
- R1: After reset every lookup misses, `vi_ready` is 1 and `wb_valid` is 0.
- R2: A fill notification never allocates a line. A lookup of a filled address that was absent still misses.
- R3: A lookup hit on a line that is neither history-shared nor code returns that line's data with `rsp_shared`=0 and `rsp_dirty` equal to the stored dirty bit. The line is invalidated, so the next lookup of it misses.
- R4: A hit on a line whose history bit is set, whose code flag is set, or whose lookup has `lk_code`=1 returns `rsp_shared`=1 and `rsp_dirty`=0. The line stays valid, and a code lookup sets the line's code flag.
- R5: A fill notification with `fill_shared`=1 for a line that is present sets that line's history bit.
- R6: A victim insert whose address matches a present line merges into that way. The new data replaces the old, and the dirty, history and code flags are ORed. No second copy is created.
- R7: A swap (lookup hit on an unshared line plus a victim insert to the same set in one cycle) places the victim in the freed way without any eviction or writeback.
- R8: A victim insert with no matching line fills the lowest-numbered invalid way before it evicts anything.
- R9: In a full set, the replacement takes the pseudo-LRU way if it is unshared. Otherwise, at each tree level it turns toward a subtree that holds an unshared way.
- R10: When all four ways of a full set are shared, the plain pseudo-LRU way is evicted. Accesses and inserts make the touched way the most recently used.
- R11: Evicting a dirty line raises `wb_valid` with that line's address and data. Evicting a clean line raises no writeback.
- R12: When an insert needs a dirty eviction and `wb_ready` is 0, `vi_ready` is 0 and the cache state is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request from an inner miss |
| lk_ready | output | 1 | Lookup accepted (always 1) |
| lk_addr | input | 26 | Lookup line address |
| lk_code | input | 1 | Lookup is an instruction fetch |
| rsp_valid | output | 1 | Response valid, same cycle as lookup |
| rsp_hit | output | 1 | Lookup hit |
| rsp_data | output | 512 | Returned line data |
| rsp_dirty | output | 1 | Ownership of dirty data passes inward |
| rsp_shared | output | 1 | Copy is retained here |
| vi_valid | input | 1 | Victim line from the inner cache |
| vi_ready | output | 1 | Victim accepted |
| vi_addr | input | 26 | Victim line address |
| vi_data | input | 512 | Victim line data |
| vi_dirty | input | 1 | Victim is dirty |
| vi_shared | input | 1 | Victim sharing-history bit |
| vi_code | input | 1 | Victim holds code |
| fill_valid | input | 1 | Memory fill notification |
| fill_addr | input | 26 | Filled line address |
| fill_shared | input | 1 | The line was observed shared |
| wb_valid | output | 1 | Dirty eviction to write back |
| wb_ready | input | 1 | Writeback accepted |
| wb_addr | output | 26 | Evicted line address |
| wb_data | output | 512 | Evicted line data |

## Verification
Wrong per-line metadata appears at the ports on the very next access to that line. A lost history or code bit makes the second lookup of a shared line miss. A stale valid bit makes a line that should be gone still hit. A corrupted pseudo-LRU state or sharing filter shows on the next insert into a full set, as a writeback address other than the one the replacement order predicts. The swap and merge paths are judged by whether any writeback appears and by which neighbours survive afterwards. Every fault therefore becomes visible within one or two transactions of its cause.

// File: rtl/vc_pkg.sv
package vc_pkg;
    localparam int VC_SETS   = 16;
    localparam int VC_WAYS   = 4;
    localparam int VC_LINE_W = 512;
    localparam int VC_ADDR_W = 26;
    localparam int VC_IDX_W  = $clog2(VC_SETS);
    localparam int VC_TAG_W  = VC_ADDR_W - VC_IDX_W;
    localparam int VC_WAY_W  = $clog2(VC_WAYS);
    localparam int VC_TREE_W = VC_WAYS - 1;
    localparam int VC_LVLS   = VC_WAY_W;

    typedef struct packed {
        logic                valid;
        logic                dirty;
        logic                hist;
        logic                code;
        logic [VC_TAG_W-1:0] tag;
    } vc_meta_t;

    typedef vc_meta_t [VC_WAYS-1:0] vc_row_t;
    typedef logic [VC_TREE_W-1:0]   vc_tree_t;
    typedef logic [VC_WAY_W-1:0]    vc_way_t;

    function automatic vc_way_t lowest_set(logic [VC_WAYS-1:0] v);
        vc_way_t r;
        r = '0;
        for (int w = VC_WAYS - 1; w >= 0; w--) begin
            if (v[w]) r = VC_WAY_W'(w);
        end
        return r;
    endfunction

    // Walk the tree; at each node follow the stored direction unless only
    // the other subtree holds a candidate way.
    function automatic vc_way_t plru_pick(vc_tree_t bits, logic [VC_WAYS-1:0] cand);
        logic [VC_WAYS-1:0] t;
        int   base, span, half, node;
        logic go_r, l_has, r_has;
        t    = {1'b0, bits};
        base = 0;
        span = VC_WAYS;
        node = 0;
        for (int l = 0; l < VC_LVLS; l++) begin
            half  = span / 2;
            l_has = 1'b0;
            r_has = 1'b0;
            for (int w = 0; w < VC_WAYS; w++) begin
                if (w >= base && w < base + half && cand[w]) l_has = 1'b1;
                if (w >= base + half && w < base + span && cand[w]) r_has = 1'b1;
            end
            go_r = t[node[VC_WAY_W-1:0]];
            if (go_r && !r_has && l_has) go_r = 1'b0;
            else if (!go_r && !l_has && r_has) go_r = 1'b1;
            if (go_r) begin
                base = base + half;
                node = 2 * node + 2;
            end else begin
                node = 2 * node + 1;
            end
            span = half;
        end
        return base[VC_WAY_W-1:0];
    endfunction

    // Point every node on the path away from the touched way.
    function automatic vc_tree_t plru_touch(vc_tree_t bits, vc_way_t way);
        logic [VC_WAYS-1:0] t;
        int   node;
        logic dir;
        t    = {1'b0, bits};
        node = 0;
        for (int l = 0; l < VC_LVLS; l++) begin
            dir = way[VC_LVLS-1-l];
            t[node[VC_WAY_W-1:0]] = ~dir;
            node = 2 * node + 1 + int'(dir);
        end
        return t[VC_TREE_W-1:0];
    endfunction
endpackage

// File: rtl/vc_way_match.sv
module vc_way_match
    import vc_pkg::*;
(
    input  vc_row_t               row,
    input  logic [VC_TAG_W-1:0]   tag,
    output logic                  hit,
    output vc_way_t               way,
    output logic [VC_WAYS-1:0]    vec
);
    for (genvar w = 0; w < VC_WAYS; w++) begin : g_cmp
        assign vec[w] = row[w].valid && (row[w].tag == tag);
    end

    always_comb begin
        hit = |vec;
        way = lowest_set(vec);
    end
endmodule

// File: rtl/vc_victim_pick.sv
module vc_victim_pick
    import vc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  vc_row_t            row,
    input  vc_tree_t           tree,
    input  logic [VC_WAYS-1:0] excl,
    output vc_way_t            pick,
    output logic               evict
);
    logic [VC_WAYS-1:0] free_vec;
    logic [VC_WAYS-1:0] shared_vec;
    logic [VC_WAYS-1:0] unsh_vec;
    logic [VC_WAYS-1:0] cand;

    for (genvar w = 0; w < VC_WAYS; w++) begin : g_cls
        assign free_vec[w]   = !row[w].valid && !excl[w];
        assign shared_vec[w] = row[w].hist || row[w].code;
        assign unsh_vec[w]   = row[w].valid && !excl[w] && !shared_vec[w];
    end

    always_comb begin
        evict = ~|free_vec;
        cand  = (|unsh_vec) ? unsh_vec : ~excl;
        if (!evict) pick = lowest_set(free_vec);
        else        pick = plru_pick(tree, cand);
    end

    assert_free_first_R8: assert property (@(posedge clk) disable iff (rst)
        !evict |-> !row[pick].valid);

    assert_unshared_pref_R9: assert property (@(posedge clk) disable iff (rst)
        (evict && |unsh_vec) |-> !shared_vec[pick]);
endmodule

// File: rtl/victim_store.sv
module victim_store
    import vc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lk_valid,
    output logic                 lk_ready,
    input  logic [VC_ADDR_W-1:0] lk_addr,
    input  logic                 lk_code,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [VC_LINE_W-1:0] rsp_data,
    output logic                 rsp_dirty,
    output logic                 rsp_shared,
    input  logic                 vi_valid,
    output logic                 vi_ready,
    input  logic [VC_ADDR_W-1:0] vi_addr,
    input  logic [VC_LINE_W-1:0] vi_data,
    input  logic                 vi_dirty,
    input  logic                 vi_shared,
    input  logic                 vi_code,
    input  logic                 fill_valid,
    input  logic [VC_ADDR_W-1:0] fill_addr,
    input  logic                 fill_shared,
    output logic                 wb_valid,
    input  logic                 wb_ready,
    output logic [VC_ADDR_W-1:0] wb_addr,
    output logic [VC_LINE_W-1:0] wb_data
);
    localparam int FLAT_W = VC_SETS * VC_WAYS;

    vc_row_t              meta_q [VC_SETS];
    vc_tree_t             plru_q [VC_SETS];
    logic [VC_LINE_W-1:0] data_q [VC_SETS][VC_WAYS];

    logic [VC_IDX_W-1:0] lk_set, vi_set, fl_set;
    logic [VC_TAG_W-1:0] lk_tag, vi_tag, fl_tag;

    assign lk_set = lk_addr[VC_IDX_W-1:0];
    assign lk_tag = lk_addr[VC_ADDR_W-1:VC_IDX_W];
    assign vi_set = vi_addr[VC_IDX_W-1:0];
    assign vi_tag = vi_addr[VC_ADDR_W-1:VC_IDX_W];
    assign fl_set = fill_addr[VC_IDX_W-1:0];
    assign fl_tag = fill_addr[VC_ADDR_W-1:VC_IDX_W];

    logic               lk_hit, vi_hit, fl_hit;
    vc_way_t            lk_hw, vi_hw, fl_hw;
    logic [VC_WAYS-1:0] lk_vec, vi_vec, fl_vec;

    vc_way_match u_lk_match (.row(meta_q[lk_set]), .tag(lk_tag), .hit(lk_hit), .way(lk_hw), .vec(lk_vec));
    vc_way_match u_vi_match (.row(meta_q[vi_set]), .tag(vi_tag), .hit(vi_hit), .way(vi_hw), .vec(vi_vec));
    vc_way_match u_fl_match (.row(meta_q[fl_set]), .tag(fl_tag), .hit(fl_hit), .way(fl_hw), .vec(fl_vec));

    vc_meta_t lk_line;
    logic     lk_fire_hit;
    logic     keep;
    logic     same_set;
    logic     swap_free;

    always_comb begin
        lk_line     = meta_q[lk_set][lk_hw];
        lk_fire_hit = lk_valid && lk_hit;
        keep        = lk_code || lk_line.hist || lk_line.code;
        same_set    = (lk_set == vi_set);
        swap_free   = lk_fire_hit && !keep && same_set && vi_valid && !vi_hit;
    end

    assign lk_ready   = 1'b1;
    assign rsp_valid  = lk_valid;
    assign rsp_hit    = lk_fire_hit;
    assign rsp_data   = data_q[lk_set][lk_hw];
    assign rsp_dirty  = lk_fire_hit && !keep && lk_line.dirty;
    assign rsp_shared = lk_fire_hit && keep;

    logic [VC_WAYS-1:0] excl;
    vc_way_t            pk_way;
    logic               pk_evict;

    assign excl = (lk_fire_hit && same_set) ? (VC_WAYS'(1) << lk_hw) : '0;

    vc_victim_pick u_pick (
        .clk   (clk),
        .rst   (rst),
        .row   (meta_q[vi_set]),
        .tree  (plru_q[vi_set]),
        .excl  (excl),
        .pick  (pk_way),
        .evict (pk_evict)
    );

    vc_way_t  vi_way;
    vc_meta_t old_line;
    vc_meta_t new_line;
    logic     wb_need;
    logic     vi_fire;

    always_comb begin
        if (vi_hit)         vi_way = vi_hw;
        else if (swap_free) vi_way = lk_hw;
        else                vi_way = pk_way;
        old_line = meta_q[vi_set][pk_way];
        wb_need  = !vi_hit && !swap_free && pk_evict && old_line.dirty;
        new_line.valid = 1'b1;
        new_line.tag   = vi_tag;
        if (vi_hit) begin
            new_line.dirty = vi_dirty  || meta_q[vi_set][vi_hw].dirty;
            new_line.hist  = vi_shared || meta_q[vi_set][vi_hw].hist;
            new_line.code  = vi_code   || meta_q[vi_set][vi_hw].code;
        end else begin
            new_line.dirty = vi_dirty;
            new_line.hist  = vi_shared;
            new_line.code  = vi_code;
        end
    end

    assign vi_ready = !wb_need || wb_ready;
    assign vi_fire  = vi_valid && vi_ready;
    assign wb_valid = vi_valid && wb_need;
    assign wb_addr  = {old_line.tag, vi_set};
    assign wb_data  = data_q[vi_set][pk_way];

    vc_tree_t lk_tree_nxt;
    vc_tree_t vi_tree_base;

    always_comb begin
        lk_tree_nxt  = plru_touch(plru_q[lk_set], lk_hw);
        vi_tree_base = (lk_fire_hit && keep && same_set) ? lk_tree_nxt : plru_q[vi_set];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < VC_SETS; s++) begin
                meta_q[s] <= '0;
                plru_q[s] <= '0;
            end
        end else begin
            if (fill_valid && fl_hit && fill_shared)
                meta_q[fl_set][fl_hw].hist <= 1'b1;
            if (lk_fire_hit) begin
                if (keep) begin
                    meta_q[lk_set][lk_hw].code <= lk_line.code || lk_code;
                    plru_q[lk_set]             <= lk_tree_nxt;
                end else begin
                    meta_q[lk_set][lk_hw].valid <= 1'b0;
                end
            end
            if (vi_fire) begin
                meta_q[vi_set][vi_way] <= new_line;
                plru_q[vi_set]         <= plru_touch(vi_tree_base, vi_way);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (vi_fire) data_q[vi_set][vi_way] <= vi_data;
    end

    logic [FLAT_W-1:0] valid_flat;
    for (genvar s = 0; s < VC_SETS; s++) begin : g_vs
        for (genvar w = 0; w < VC_WAYS; w++) begin : g_vw
            assign valid_flat[s*VC_WAYS+w] = meta_q[s][w].valid;
        end
    end

    assert_single_copy_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_vec) && $onehot0(vi_vec) && $onehot0(fl_vec));

    assert_no_fill_alloc_R2: assert property (@(posedge clk) disable iff (rst)
        !vi_fire |=> ($countones(valid_flat) <= $past($countones(valid_flat))));

    assert_unshared_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (lk_fire_hit && !keep && !(vi_valid && same_set))
        |=> !meta_q[$past(lk_set)][$past(lk_hw)].valid);

    assert_shared_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (lk_fire_hit && keep && !(vi_valid && same_set))
        |=> meta_q[$past(lk_set)][$past(lk_hw)].valid);

    assert_swap_no_wb_R7: assert property (@(posedge clk) disable iff (rst)
        swap_free |-> (!wb_valid && vi_ready));

    assert_stall_cause_R12: assert property (@(posedge clk) disable iff (rst)
        (vi_valid && !vi_ready) |-> (wb_valid && !wb_ready));

    assert_stall_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (vi_valid && !vi_ready && !lk_valid && !fill_valid) |=> $stable(valid_flat));
endmodule

// File: tb/sim_victim_store.sv
module sim_victim_store;
    import vc_pkg::*;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(PERIOD/2) clk = ~clk;

    logic                 lk_valid = 0, lk_code = 0;
    logic [VC_ADDR_W-1:0] lk_addr = '0;
    logic                 lk_ready, rsp_valid, rsp_hit, rsp_dirty, rsp_shared;
    logic [VC_LINE_W-1:0] rsp_data;
    logic                 vi_valid = 0, vi_dirty = 0, vi_shared = 0, vi_code = 0;
    logic [VC_ADDR_W-1:0] vi_addr = '0;
    logic [VC_LINE_W-1:0] vi_data = '0;
    logic                 vi_ready;
    logic                 fill_valid = 0, fill_shared = 0;
    logic [VC_ADDR_W-1:0] fill_addr = '0;
    logic                 wb_valid, wb_ready = 1;
    logic [VC_ADDR_W-1:0] wb_addr;
    logic [VC_LINE_W-1:0] wb_data;

    victim_store u0 (.*);

    int checks = 0, fails = 0;
    logic                 r_hit, r_dirty, r_shared, c_ready, c_wbv;
    logic [VC_LINE_W-1:0] r_data, c_wbd;
    logic [VC_ADDR_W-1:0] c_wba;

    function automatic logic [VC_ADDR_W-1:0] mka(int tag, int set);
        return {tag[VC_TAG_W-1:0], set[VC_IDX_W-1:0]};
    endfunction

    function automatic logic [VC_LINE_W-1:0] mkd(logic [VC_ADDR_W-1:0] a, int salt);
        return {(VC_LINE_W/32){32'(a) ^ salt}};
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic lookup(logic [VC_ADDR_W-1:0] a, logic code);
        @(negedge clk);
        lk_valid = 1; lk_addr = a; lk_code = code;
        #1;
        r_hit = rsp_hit; r_data = rsp_data; r_dirty = rsp_dirty; r_shared = rsp_shared;
        @(posedge clk); #1;
        lk_valid = 0; lk_code = 0;
    endtask

    task automatic insert(logic [VC_ADDR_W-1:0] a, logic [VC_LINE_W-1:0] d,
                          logic dirty, logic shared, logic code);
        @(negedge clk);
        vi_valid = 1; vi_addr = a; vi_data = d; vi_dirty = dirty; vi_shared = shared; vi_code = code;
        #1;
        c_ready = vi_ready; c_wbv = wb_valid; c_wba = wb_addr; c_wbd = wb_data;
        @(posedge clk); #1;
        vi_valid = 0;
    endtask

    task automatic fill(logic [VC_ADDR_W-1:0] a, logic shared);
        @(negedge clk);
        fill_valid = 1; fill_addr = a; fill_shared = shared;
        @(posedge clk); #1;
        fill_valid = 0;
    endtask

    task automatic t_reset();
        lookup(mka(3, 0), 0);
        chk("R1", "hit after reset", 64'(r_hit), 0);
        #1;
        chk("R1", "vi_ready idle", 64'(vi_ready), 1);
        chk("R1", "wb_valid idle", 64'(wb_valid), 0);
    endtask

    task automatic t_fill();
        fill(mka(5, 1), 1);
        lookup(mka(5, 1), 0);
        chk("R2", "hit after fill", 64'(r_hit), 0);
    endtask

    task automatic t_exclusive();
        logic [VC_ADDR_W-1:0] a = mka(1, 2);
        insert(a, mkd(a, 7), 1, 0, 0);
        lookup(a, 0);
        chk("R3", "hit", 64'(r_hit), 1);
        chk("R3", "data", 64'(r_data == mkd(a, 7)), 1);
        chk("R3", "dirty", 64'(r_dirty), 1);
        chk("R3", "shared", 64'(r_shared), 0);
        lookup(a, 0);
        chk("R3", "second lookup", 64'(r_hit), 0);
    endtask

    task automatic t_retain();
        logic [VC_ADDR_W-1:0] b = mka(1, 3), c = mka(2, 3), d = mka(3, 3);
        insert(b, mkd(b, 1), 1, 1, 0);
        lookup(b, 0);
        chk("R4", "hist hit", 64'(r_hit), 1);
        chk("R4", "hist shared", 64'(r_shared), 1);
        chk("R4", "hist dirty", 64'(r_dirty), 0);
        lookup(b, 0);
        chk("R4", "hist kept", 64'(r_hit), 1);
        insert(c, mkd(c, 1), 0, 0, 1);
        lookup(c, 0);
        lookup(c, 0);
        chk("R4", "code kept", 64'(r_hit), 1);
        insert(d, mkd(d, 1), 0, 0, 0);
        lookup(d, 1);
        chk("R4", "fetch shared", 64'(r_shared), 1);
        lookup(d, 0);
        chk("R4", "fetch kept", 64'(r_hit), 1);
    endtask

    task automatic t_fillmark();
        logic [VC_ADDR_W-1:0] e = mka(1, 4);
        insert(e, mkd(e, 2), 0, 0, 0);
        fill(e, 1);
        lookup(e, 0);
        chk("R5", "marked shared", 64'(r_shared), 1);
        lookup(e, 0);
        chk("R5", "marked kept", 64'(r_hit), 1);
    endtask

    task automatic t_merge();
        logic [VC_ADDR_W-1:0] f = mka(1, 5);
        insert(f, mkd(f, 1), 0, 1, 0);
        lookup(f, 0);
        insert(f, mkd(f, 2), 1, 0, 0);
        chk("R6", "merge no wb", 64'(c_wbv), 0);
        lookup(f, 0);
        chk("R6", "merged data", 64'(r_data == mkd(f, 2)), 1);
        for (int i = 2; i <= 4; i++) begin
            insert(mka(i, 5), mkd(mka(i, 5), 3), 1, 0, 0);
            chk("R6", "room left", 64'(c_wbv), 0);
        end
        insert(mka(9, 5), mkd(mka(9, 5), 3), 1, 0, 0);
        chk("R6", "set full", 64'(c_wbv), 1);
        chk("R9", "skip shared", 64'(c_wba), 64'(mka(2, 5)));
    endtask

    task automatic t_swap();
        for (int i = 1; i <= 4; i++) insert(mka(i, 6), mkd(mka(i, 6), 4), 1, 0, 0);
        @(negedge clk);
        lk_valid = 1; lk_addr = mka(1, 6); lk_code = 0;
        vi_valid = 1; vi_addr = mka(7, 6); vi_data = mkd(mka(7, 6), 5);
        vi_dirty = 1; vi_shared = 0; vi_code = 0;
        #1;
        chk("R7", "swap hit", 64'(rsp_hit), 1);
        chk("R7", "swap data", 64'(rsp_data == mkd(mka(1, 6), 4)), 1);
        chk("R7", "swap ready", 64'(vi_ready), 1);
        chk("R7", "swap no wb", 64'(wb_valid), 0);
        @(posedge clk); #1;
        lk_valid = 0; vi_valid = 0;
        lookup(mka(7, 6), 0);
        chk("R7", "victim present", 64'(r_data == mkd(mka(7, 6), 5)), 1);
        lookup(mka(1, 6), 0);
        chk("R7", "swapped out", 64'(r_hit), 0);
        lookup(mka(2, 6), 0);
        chk("R7", "neighbour kept", 64'(r_hit), 1);
    endtask

    task automatic t_repl();
        insert(mka(1, 7), mkd(mka(1, 7), 6), 1, 1, 0);
        chk("R8", "free way 0", 64'(c_wbv), 0);
        for (int i = 2; i <= 4; i++) begin
            insert(mka(i, 7), mkd(mka(i, 7), 6), 1, 0, 0);
            chk("R8", "free way", 64'(c_wbv), 0);
        end
        insert(mka(5, 7), mkd(mka(5, 7), 6), 1, 0, 0);
        chk("R11", "dirty wb", 64'(c_wbv), 1);
        chk("R9", "unshared victim", 64'(c_wba), 64'(mka(2, 7)));
        chk("R11", "wb data", 64'(c_wbd == mkd(mka(2, 7), 6)), 1);
        lookup(mka(1, 7), 0);
        chk("R9", "shared survives", 64'(r_hit), 1);
    endtask

    task automatic t_allshared();
        for (int i = 1; i <= 4; i++) insert(mka(i, 8), mkd(mka(i, 8), 8), 1, 1, 0);
        insert(mka(5, 8), mkd(mka(5, 8), 8), 1, 1, 0);
        chk("R10", "wb", 64'(c_wbv), 1);
        chk("R10", "plru victim", 64'(c_wba), 64'(mka(1, 8)));
    endtask

    task automatic t_clean();
        for (int i = 1; i <= 4; i++) insert(mka(i, 9), mkd(mka(i, 9), 9), 0, 0, 0);
        insert(mka(5, 9), mkd(mka(5, 9), 9), 0, 0, 0);
        chk("R11", "clean no wb", 64'(c_wbv), 0);
        lookup(mka(1, 9), 0);
        chk("R11", "clean evicted", 64'(r_hit), 0);
        lookup(mka(2, 9), 0);
        chk("R11", "other kept", 64'(r_hit), 1);
    endtask

    task automatic t_backpressure();
        for (int i = 1; i <= 4; i++) insert(mka(i, 10), mkd(mka(i, 10), 10), 1, 0, 0);
        wb_ready = 0;
        insert(mka(5, 10), mkd(mka(5, 10), 10), 1, 0, 0);
        chk("R12", "stalled", 64'(c_ready), 0);
        chk("R12", "wb offered", 64'(c_wbv), 1);
        wb_ready = 1;
        lookup(mka(5, 10), 0);
        chk("R12", "not inserted", 64'(r_hit), 0);
        lookup(mka(1, 10), 0);
        chk("R12", "victim kept", 64'(r_hit), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_fill();
        t_exclusive();
        t_retain();
        t_fillmark();
        t_merge();
        t_swap();
        t_repl();
        t_allshared();
        t_clean();
        t_backpressure();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 50000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule